// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block runs ahead of instruction execution in a 16-bit segmented processor. It holds a code segment value and a fetch offset, and forms 20-bit physical fetch addresses from them. Whenever the byte queue has room for a whole bus word, it asks memory for that word. It places the two returned bytes in a six-entry byte queue in address order.

The execution side reads the byte at the head of the queue. Each time it removes a byte, it says whether that byte opens a new instruction. A jump is signalled with the flush strobe, which carries the new segment and offset. The flush empties the queue and restarts fetching at the target. Any word still in flight at that moment is thrown away when it arrives.

A 2-bit status output reports, one clock after the event, what the queue did on that clock. A separate restart input takes effect only after it has been held high for four consecutive clocks. It then returns the fetch pointer to its power-up location.

Top module: `ifetch_queue`

## Requirements
- R1: The fetch address is `(segment * 16 + offset) mod 2^20`, so it wraps around the top of the 1 MiB space (for example FFFF:0010 fetches from 00000h).
- R2: After `rst_n` is released, and after a qualified restart, the segment is FFFFh and the offset is 0000h. The first request is raised at the first clock edge and addresses FFFF0h.
- R3: `sys_reset` acts only on the fourth consecutive clock edge at which it is sampled high, and on every edge after that while it stays high. On each such edge it empties the queue, reports status 10, reloads FFFF:0000 and issues no request. A pulse of three clocks or fewer changes nothing.
- R4: `mem_req`, once raised, stays high with `mem_addr` unchanged until an edge with `mem_ready` high. At that edge `mem_rdata[7:0]` holds the byte at `mem_addr` and `mem_rdata[15:8]` holds the byte at `mem_addr+1`. Only one request is outstanding at a time.
- R5: A new request is raised only at an edge where the queue holds at most 4 bytes, so that at least 2 entries are free.
- R6: The queue holds at most 6 bytes and hands them out in address order. `head_valid` is high exactly when it is non-empty, and `head_byte` shows the oldest byte. A pop while the queue is empty is ignored and reports status 00.
- R7: `qstat` reports 01 after a pop marked first-of-instruction, 11 after a pop not so marked, and 00 after an edge with no queue operation. Each value is visible during the cycle that follows the edge.
- R8: A flush empties the queue, reports status 10, and reloads the fetch pointer from `flush_seg`/`flush_off`. When a pop and a flush arrive on the same edge, the flush wins and the pop is dropped.
- R9: A word that is in flight at a flush or a qualified restart is discarded when its `mem_ready` arrives. The first byte delivered afterwards comes from the new target.
- R10: Each issued request advances the offset by 2 modulo 2^16, so the segment stays fixed while the offset wraps (1000:FFFE is followed by 1000:0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sys_reset | input | 1 | Restart request, qualified after four clocks high |
| flush | input | 1 | Jump strobe: empty the queue and reload the fetch pointer |
| flush_seg | input | 16 | New code segment on flush |
| flush_off | input | 16 | New fetch offset on flush |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | 20 | Physical address of the requested word |
| mem_ready | input | 1 | Memory completes the request this edge |
| mem_rdata | input | 16 | Returned word, lower byte at `mem_addr` |
| pop | input | 1 | Execution side removes the head byte |
| pop_first | input | 1 | The popped byte starts a new instruction |
| head_valid | output | 1 | Queue is non-empty |
| head_byte | output | 8 | Oldest byte in the queue |
| qstat | output | 2 | Queue operation reported for the previous edge |

## Verification
`qstat` and `head_valid` are due one edge after a pop or flush is sampled. A request is due one edge after the queue has room, and returned bytes reach `head_byte` on the edge that accepts `mem_ready`. The bench drives every input just after a falling edge and samples each output at the next falling edge, which is exactly one register stage later. The memory model in the bench derives each data byte from its own address and counts its wait states in falling edges. Because of this, a wrong address, a lost discard or a byte-order error appears directly as a wrong `head_byte`, compared against addresses computed from the R1/R10 rules.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;

endpackage

// File: rtl/pfq_rst_qual.sv
module pfq_rst_qual #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic active
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    active = req && (cnt_q == LAST);
    cnt_en = req || (cnt_q != '0);
    if (!req)        cnt_d = '0;
    else if (active) cnt_d = cnt_q;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  parameter int STEP  = 2,
  parameter logic [SEG_W-1:0] RST_SEG = '1,
  parameter logic [OFF_W-1:0] RST_OFF = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             jump,
  input  logic [SEG_W-1:0] jump_seg,
  input  logic [OFF_W-1:0] jump_off,
  input  logic             room,
  input  logic             mem_ready,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  output logic             push
);
  localparam int SHIFT = PA_W - SEG_W;

  logic [SEG_W-1:0] seg_q, seg_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [PA_W-1:0]  addr_q, addr_d, phys;
  logic             req_q, req_d, drop_q, drop_d;
  logic             accept, redirect, issue, ptr_en, req_en;

  always_comb begin
    phys     = {seg_q, {SHIFT{1'b0}}} + PA_W'(off_q);
    accept   = req_q && mem_ready;
    redirect = restart || jump;
    issue    = !redirect && !req_q && room;
    push     = accept && !drop_q && !redirect;
  end

  always_comb begin
    seg_d  = seg_q;
    off_d  = off_q;
    addr_d = addr_q;
    req_d  = req_q;
    drop_d = drop_q;
    if (accept) begin
      req_d  = 1'b0;
      drop_d = 1'b0;
    end
    if (restart) begin
      seg_d = RST_SEG;
      off_d = RST_OFF;
    end else if (jump) begin
      seg_d = jump_seg;
      off_d = jump_off;
    end else if (issue) begin
      req_d  = 1'b1;
      addr_d = phys;
      off_d  = off_q + OFF_W'(STEP);
    end
    if (redirect && req_q && !mem_ready) drop_d = 1'b1;
    ptr_en = redirect || issue;
    req_en = accept || issue || redirect;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= RST_SEG;
      off_q <= RST_OFF;
    end else if (ptr_en) begin
      seg_q <= seg_d;
      off_q <= off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      drop_q <= 1'b0;
      addr_q <= '0;
    end else if (req_en) begin
      req_q  <= req_d;
      drop_q <= drop_d;
      addr_q <= addr_d;
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
endmodule

// File: rtl/pfq_buf.sv
module pfq_buf #(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      push,
  input  logic [LANES*BYTE_W-1:0]   push_data,
  input  logic                      pop,
  output logic                      take,
  output logic [BYTE_W-1:0]         head,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] store_q [DEPTH];
  logic [BYTE_W-1:0] lane    [LANES];
  logic [BYTE_W-1:0] wd      [DEPTH];
  logic [DEPTH-1:0]  we;
  logic [PW-1:0]     rd_q, rd_d, wr_q, wr_d;
  logic [LW-1:0]     lvl_q, lvl_d;
  logic              ptr_en;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int unsigned n);
    logic [PW:0] s;
    s = {1'b0, p} + (PW+1)'(n);
    if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
    return s[PW-1:0];
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane[l] = push_data[l*BYTE_W +: BYTE_W];
  end

  always_comb begin
    take = pop && !clear && (lvl_q != '0);
    for (int e = 0; e < DEPTH; e++) begin
      we[e] = 1'b0;
      wd[e] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (push && !clear && (adv(wr_q, l) == PW'(e))) begin
          we[e] = 1'b1;
          wd[e] = lane[l];
        end
      end
    end
  end

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    lvl_d = lvl_q;
    if (clear) begin
      rd_d  = '0;
      wr_d  = '0;
      lvl_d = '0;
    end else begin
      if (take) rd_d = adv(rd_q, 1);
      if (push) wr_d = adv(wr_q, LANES);
      lvl_d = lvl_q + (push ? LW'(LANES) : LW'(0)) - (take ? LW'(1) : LW'(0));
    end
    ptr_en = clear || take || push;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else if (ptr_en) begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (we[e]) store_q[e] <= wd[e];
    end
  end

  assign head  = store_q[rd_q];
  assign level = lvl_q;
endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int SEG_W    = 16,
  parameter int OFF_W    = 16,
  parameter int PA_W     = 20,
  parameter int BUS_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int RST_HOLD = 4,
  parameter logic [SEG_W-1:0] RST_SEG = '1,
  parameter logic [OFF_W-1:0] RST_OFF = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_reset,
  input  logic              flush,
  input  logic [SEG_W-1:0]  flush_seg,
  input  logic [OFF_W-1:0]  flush_off,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_ready,
  input  logic [BUS_W-1:0]  mem_rdata,
  input  logic              pop,
  input  logic              pop_first,
  output logic              head_valid,
  output logic [BYTE_W-1:0] head_byte,
  output logic [1:0]        qstat
);
  localparam int LANES = BUS_W / BYTE_W;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          rst_act, push, room, take, wipe;
  logic [LW-1:0] occ;
  qstat_e        qs_q, qs_d;

  pfq_rst_qual #(.HOLD(RST_HOLD)) u_rq (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (sys_reset),
    .active (rst_act)
  );

  pfq_fetch #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .STEP(LANES),
    .RST_SEG(RST_SEG), .RST_OFF(RST_OFF)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (rst_act),
    .jump      (flush),
    .jump_seg  (flush_seg),
    .jump_off  (flush_off),
    .room      (room),
    .mem_ready (mem_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .push      (push)
  );

  pfq_buf #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .LANES(LANES)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (wipe),
    .push      (push),
    .push_data (mem_rdata),
    .pop       (pop),
    .take      (take),
    .head      (head_byte),
    .level     (occ)
  );

  always_comb begin
    wipe       = rst_act || flush;
    room       = occ <= LW'(DEPTH - LANES);
    head_valid = occ != '0;
    if (wipe)           qs_d = QS_FLUSH;
    else if (take)      qs_d = pop_first ? QS_FIRST : QS_NEXT;
    else                qs_d = QS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qs_q <= QS_IDLE;
    else        qs_q <= qs_d;
  end

  assign qstat = qs_q;
endmodule

// File: rtl/ifetch_queue_chk.sv
module ifetch_queue_chk #(
  parameter int DEPTH = 6,
  parameter int LANES = 2,
  parameter int PA_W  = 20,
  parameter int LW    = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_ready,
  input logic [PA_W-1:0] mem_addr,
  input logic            pop,
  input logic            head_valid,
  input logic [1:0]      qstat,
  input logic [LW-1:0]   occ
);
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  a_r5_room_at_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (occ <= LW'(DEPTH - LANES)));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= LW'(DEPTH));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (qstat == 2'b10) |-> !head_valid);

  a_r7_pop_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (qstat == 2'b01 || qstat == 2'b11) |-> $past(pop));
endmodule

bind ifetch_queue ifetch_queue_chk #(
  .DEPTH (DEPTH),
  .LANES (BUS_W / BYTE_W),
  .PA_W  (PA_W),
  .LW    ($clog2(DEPTH + 1))
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .pop        (pop),
  .head_valid (head_valid),
  .qstat      (qstat),
  .occ        (occ)
);

// File: tb/test_ifetch_queue.sv
module test_ifetch_queue;
  localparam int CLK_P = 10;
  localparam int NVEC  = 5;
  // {seg, off, latency, byte count, first-of-instruction mask}
  localparam logic [59:0] VECS [NVEC] = '{
    {16'h1234, 16'h0010, 4'd1, 8'd8,  16'h0011},
    {16'h1000, 16'hFFFE, 4'd2, 8'd6,  16'h0001},
    {16'hFFFF, 16'h0010, 4'd3, 8'd4,  16'h0005},
    {16'h0ABC, 16'h0101, 4'd1, 8'd10, 16'h0009},
    {16'hF000, 16'h8000, 4'd4, 8'd5,  16'h0003}
  };

  logic        clk = 1'b0;
  logic        rst_n, sys_reset, flush, mem_ready, pop, pop_first;
  logic [15:0] flush_seg, flush_off, mem_rdata;
  logic        mem_req, head_valid;
  logic [19:0] mem_addr;
  logic [7:0]  head_byte;
  logic [1:0]  qstat;
  int          n_chk = 0, n_bad = 0, cyc = 0, lat = 3, wcnt = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  ifetch_queue i_ifetch_queue (
    .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .flush(flush),
    .flush_seg(flush_seg), .flush_off(flush_off), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .pop(pop), .pop_first(pop_first), .head_valid(head_valid),
    .head_byte(head_byte), .qstat(qstat)
  );

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]};
  endfunction

  function automatic logic [19:0] baddr(input logic [15:0] s, input logic [15:0] o, input int k);
    logic [15:0] w;
    logic [19:0] p;
    w = o + 16'(2 * (k / 2));
    p = {s, 4'h0} + {4'h0, w};
    return p + 20'(k % 2);
  endfunction

  // memory model: responds after lat falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      wcnt = 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      wcnt = wcnt + 1;
      if (wcnt >= lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= {mbyte(mem_addr + 20'd1), mbyte(mem_addr)};
      end
    end
  end

  task automatic report();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog act=%0d exp<=20000", cyc);
      report();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // wait for a byte, check it, pop it, check the reported status (R6, R7)
  task automatic take_byte(input logic [7:0] exp, input bit first, input string tag);
    int t = 0;
    while (!head_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk({tag, " R6 head_valid"}, 32'(head_valid), 32'd1);
    chk({tag, " R6 head_byte"}, 32'(head_byte), 32'(exp));
    pop = 1'b1;
    pop_first = first;
    @(negedge clk);
    pop = 1'b0;
    chk({tag, " R7 qstat"}, 32'(qstat), first ? 32'd1 : 32'd2 + 32'd1);
  endtask

  task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
    flush = 1'b1;
    flush_seg = s;
    flush_off = o;
    @(negedge clk);
    flush = 1'b0;
    chk("R8 flush status", 32'(qstat), 32'd2);
    chk("R8 flush empties", 32'(head_valid), 32'd0);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (mem_req && t < 100) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    rst_n = 1'b0; sys_reset = 1'b0; flush = 1'b0; pop = 1'b0; pop_first = 1'b0;
    flush_seg = '0; flush_off = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset qstat", 32'(qstat), 32'd0);
    chk("R6 reset empty", 32'(head_valid), 32'd0);
    chk("R4 reset no req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 first req", 32'(mem_req), 32'd1);
    chk("R2 first addr", 32'(mem_addr), 32'hFFFF0);
    @(negedge clk);
    chk("R4 req held", 32'(mem_req), 32'd1);
    chk("R4 addr stable", 32'(mem_addr), 32'hFFFF0);
    for (int k = 0; k < 6; k++)
      take_byte(mbyte(baddr(16'hFFFF, 16'h0000, k)), (k == 0) || (k == 3), "R2 boot stream");

    // table of flush targets walked by one loop (R1, R10)
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] s, o, m;
      int n;
      s = VECS[v][59:44];
      o = VECS[v][43:28];
      lat = int'(VECS[v][27:24]);
      n = int'(VECS[v][23:16]);
      m = VECS[v][15:0];
      wait_idle();
      do_flush(s, o);
      @(negedge clk);
      chk("R1 target addr", 32'(mem_addr), 32'(baddr(s, o, 0)));
      for (int k = 0; k < n; k++)
        take_byte(mbyte(baddr(s, o, k)), m[k], "R10 vector stream");
    end

    // fill, room rule and capacity (R5, R6)
    lat = 1;
    wait_idle();
    do_flush(16'h2000, 16'h0000);
    repeat (20) @(negedge clk);
    chk("R5 full no req", 32'(mem_req), 32'd0);
    lat = 12;
    take_byte(mbyte(baddr(16'h2000, 16'h0, 0)), 1'b1, "R6 fill");
    chk("R5 five held no req", 32'(mem_req), 32'd0);
    take_byte(mbyte(baddr(16'h2000, 16'h0, 1)), 1'b0, "R6 fill");
    chk("R5 four held edge used five", 32'(mem_req), 32'd0);
    take_byte(mbyte(baddr(16'h2000, 16'h0, 2)), 1'b0, "R6 fill");
    chk("R5 req at four", 32'(mem_req), 32'd1);
    for (int k = 3; k < 6; k++)
      take_byte(mbyte(baddr(16'h2000, 16'h0, k)), 1'b0, "R6 fill");
    chk("R6 six bytes only", 32'(head_valid), 32'd0);
    pop = 1'b1; pop_first = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    chk("R6 pop on empty", 32'(qstat), 32'd0);
    for (int k = 6; k < 8; k++)
      take_byte(mbyte(baddr(16'h2000, 16'h0, k)), 1'b0, "R6 after empty pop");

    // in-flight discard (R9)
    lat = 6;
    wait_idle();
    do_flush(16'h3000, 16'h0000);
    @(negedge clk);
    chk("R9 req in flight", 32'(mem_req), 32'd1);
    do_flush(16'h4000, 16'h0100);
    for (int k = 0; k < 4; k++)
      take_byte(mbyte(baddr(16'h4000, 16'h0100, k)), k == 0, "R9 new target");

    // short restart pulse ignored (R3)
    lat = 1;
    repeat (20) @(negedge clk);
    sys_reset = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 short pulse status", 32'(qstat), 32'd0);
    end
    sys_reset = 1'b0;
    chk("R3 short pulse keeps bytes", 32'(head_valid), 32'd1);
    for (int k = 4; k < 6; k++)
      take_byte(mbyte(baddr(16'h4000, 16'h0100, k)), 1'b0, "R3 continuation");

    // qualified restart (R3, R2)
    repeat (20) @(negedge clk);
    sys_reset = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 not yet", 32'(head_valid), 32'd1);
    @(negedge clk);
    chk("R3 restart status", 32'(qstat), 32'd2);
    chk("R3 restart empties", 32'(head_valid), 32'd0);
    @(negedge clk);
    chk("R3 held no req", 32'(mem_req), 32'd0);
    sys_reset = 1'b0;
    @(negedge clk);
    chk("R2 restart req", 32'(mem_req), 32'd1);
    chk("R2 restart addr", 32'(mem_addr), 32'hFFFF0);

    // flush beats pop on the same edge (R8)
    repeat (10) @(negedge clk);
    flush = 1'b1; flush_seg = 16'h6000; flush_off = 16'h0020;
    pop = 1'b1; pop_first = 1'b1;
    @(negedge clk);
    flush = 1'b0; pop = 1'b0;
    chk("R8 flush wins status", 32'(qstat), 32'd2);
    chk("R8 flush wins empty", 32'(head_valid), 32'd0);
    for (int k = 0; k < 4; k++)
      take_byte(mbyte(baddr(16'h6000, 16'h0020, k)), k == 0, "R8 after flush");

    done = 1;
    report();
  end
endmodule